// File: doc/BRIEF.md
# Extended-Range Degamma Lookup Unit

This block linearises the three components of each pixel before the colour-space conversion stage. It holds a single curve of 35 points that all three components share, and it interpolates linearly between neighbouring points. The first 33 points divide the input interval from 0 to 1.0 into 32 equal segments. The two remaining points extend the curve to inputs of 3.0 and 7.0, so the segment layout is non-uniform. Pixels arrive as fixed-point words with 16 fractional bits. Each pixel leaves exactly two clock cycles after it enters. When the unit is disabled, the pixel passes through unchanged with the same latency.

Software loads the curve through a small register port that has three registers: a pointer, a data window and a mode word. The pointer has an auto-advance flag. When that flag is set, each access to the data window moves the pointer to the next point. Setting the flag never changes the pointer field, so software first writes the starting point with the flag clear and then sets the flag. Software can then stream all 35 values. After reset the curve is the identity on [0, 1.0], and the two extended points hold 1.0.

Top module: `degamma_lut`

## Requirements
- R1: After reset, point i (for i from 0 to 32) holds i*2048, points 33 and 34 hold 65536, the pointer is 0 with auto-advance off, and the mode word reads 0.
- R2: A write to the pointer register (address 1) with bit 8 clear turns auto-advance off. It loads bits 5:0 as the pointer when they are 34 or less. A larger value leaves the pointer unchanged. The pointer never exceeds 34.
- R3: A write to the pointer register with bit 8 set turns auto-advance on and leaves the pointer unchanged, whatever bits 5:0 hold. Reading address 1 returns the pointer in bits 5:0 and the flag in bit 8.
- R4: A write to the data window (address 2) stores bits 16:0 into the point selected by the pointer. With auto-advance on, the pointer then increments, but it stays at 34 once it reaches 34.
- R5: A read of address 2 returns the selected point in bits 16:0 on the cycle after the read strobe. With auto-advance on, the read also advances the pointer under the same rule as R4. With auto-advance off, the pointer is unchanged.
- R6: The mode word (address 0) stores bit 31 (degamma enable), bit 30 (a flag for a later gamma stage) and bits 1:0 (a mode code that is held but not used). A read returns those bits and zeros everywhere else.
- R7: The output valid follows the input valid by exactly two cycles. When the enable bit is clear, the output equals the input.
- R8: With the unit enabled, an input x below 1.0 uses point k = x[15:11] and point k+1. The output is e[k] + floor((e[k+1]-e[k]) * x[10:0] / 2048).
- R9: With the unit enabled, an input x from 1.0 up to but not including 3.0 gives e32 + floor((e33-e32) * (x-65536) / 131072).
- R10: With the unit enabled, an input x from 3.0 up to but not including 7.0 gives e33 + floor((e34-e33) * (x-196608) / 262144). An input of 7.0 or more gives e34.
- R11: A pixel accepted in the same cycle as a data-window write is converted with the curve as it stood before that write.
- R12: A pixel accepted in the same cycle as a mode-word write uses the enable bit as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 2 | Register select: 0 mode, 1 pointer, 2 data window |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Write strobe; takes priority over reg_rd |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_i | input | 57 | Three 19-bit components (3.16 unsigned), component c at bits c*19 and up |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 57 | Three converted components, same packing |

## Verification
Two things can happen in the same clock edge here: a pixel can read the curve while the register port rewrites it, and a pixel can be accepted while the enable bit changes. The bench provokes the first case by pointing at one entry and then presenting a pixel that lands exactly on that entry at the same edge as a data-window write to it. That pixel must show the old value, and a second pixel sent right after must show the new one. For the second case, the bench clears the enable bit at the same edge as a pixel that would be remapped. The pixel must still be remapped, and the next pixel must come out bypassed.

// File: rtl/dgl_pkg.sv
package dgl_pkg;
   localparam int NENT      = 35;
   localparam int SEG_BITS  = 5;
   localparam int PT_ONE    = 32;
   localparam int PT_THREE  = 33;
   localparam int PT_SEVEN  = 34;
   localparam int IDX_W     = $clog2(NENT);

   typedef enum logic [1:0] {
      RS_MODE = 2'd0,
      RS_PTR  = 2'd1,
      RS_DATA = 2'd2,
      RS_NONE = 2'd3
   } reg_sel_e;

   function automatic longint ident_point(int i, int frac);
      if (i <= PT_ONE) return (longint'(i) << frac) / PT_ONE;
      return longint'(1) << frac;
   endfunction
endpackage

// File: rtl/dgl_regs.sv
module dgl_regs
   import dgl_pkg::*;
#(
   parameter int ENTRY_W  = 17,
   parameter int PIX_FRAC = 16,
   parameter int AINC_BIT = 8
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic [1:0]                         addr,
   input  logic [31:0]                        wdata,
   input  logic                               wr,
   input  logic                               rd,
   output logic [31:0]                        rdata,
   output logic [NENT-1:0][ENTRY_W-1:0]       curve,
   output logic [IDX_W-1:0]                   ptr,
   output logic                               ainc,
   output logic                               deg_en
);
   localparam logic [IDX_W-1:0] LAST_PT = IDX_W'(NENT - 1);

   logic       post_flag;
   logic [1:0] mode_code;
   logic [31:0] rd_mux;
   logic        step_ok;
   logic        unused_w;

   assign unused_w = ^wdata;
   assign step_ok  = ainc && (ptr != LAST_PT);

   always_comb begin
      rd_mux = '0;
      unique case (reg_sel_e'(addr))
         RS_MODE: begin
            rd_mux[31]  = deg_en;
            rd_mux[30]  = post_flag;
            rd_mux[1:0] = mode_code;
         end
         RS_PTR: begin
            rd_mux[AINC_BIT]    = ainc;
            rd_mux[IDX_W-1:0]   = ptr;
         end
         RS_DATA: rd_mux[ENTRY_W-1:0] = curve[ptr];
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NENT; i++)
            curve[i] <= ENTRY_W'(ident_point(i, PIX_FRAC));
         ptr       <= '0;
         ainc      <= 1'b0;
         deg_en    <= 1'b0;
         post_flag <= 1'b0;
         mode_code <= 2'b00;
         rdata     <= '0;
      end else if (wr) begin
         unique case (reg_sel_e'(addr))
            RS_MODE: begin
               deg_en    <= wdata[31];
               post_flag <= wdata[30];
               mode_code <= wdata[1:0];
            end
            RS_PTR: begin
               if (wdata[AINC_BIT]) begin
                  ainc <= 1'b1;
               end else begin
                  ainc <= 1'b0;
                  if (wdata[IDX_W-1:0] <= LAST_PT) ptr <= wdata[IDX_W-1:0];
               end
            end
            RS_DATA: begin
               curve[ptr] <= wdata[ENTRY_W-1:0];
               if (step_ok) ptr <= ptr + IDX_W'(1);
            end
            default: ;
         endcase
      end else if (rd) begin
         rdata <= rd_mux;
         if (reg_sel_e'(addr) == RS_DATA && step_ok) ptr <= ptr + IDX_W'(1);
      end
   end
endmodule

// File: rtl/dgl_chan.sv
module dgl_chan
   import dgl_pkg::*;
#(
   parameter int PIX_FRAC = 16,
   parameter int PIX_INT  = 3,
   parameter int ENTRY_W  = 17
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          accept,
   input  logic                          en,
   input  logic [PIX_INT+PIX_FRAC-1:0]   x,
   input  logic [NENT-1:0][ENTRY_W-1:0]  curve,
   output logic [PIX_INT+PIX_FRAC-1:0]   y
);
   localparam int PIX_W = PIX_INT + PIX_FRAC;
   localparam int W_B   = PIX_FRAC + 2;
   localparam int BL    = PIX_FRAC - SEG_BITS;
   localparam int PW    = ENTRY_W + W_B + 3;
   localparam logic [PIX_W-1:0] X1 = PIX_W'(1) << PIX_FRAC;
   localparam logic [PIX_W-1:0] X3 = PIX_W'(3) << PIX_FRAC;
   localparam logic [PIX_W-1:0] X7 = PIX_W'(7) << PIX_FRAC;

   logic [ENTRY_W-1:0] a0, b0, a1, b1;
   logic [W_B-1:0]     w0, w1;
   logic [PIX_W-1:0]   x1, d_one, d_three;
   logic               byp1;
   logic [SEG_BITS-1:0] k;
   logic [IDX_W-1:0]   kn;
   logic signed [ENTRY_W+1:0] diff;
   logic signed [PW-1:0]      prod, sum;
   logic unused_bits;

   assign k       = x[PIX_FRAC-1 -: SEG_BITS];
   assign kn      = IDX_W'(k) + IDX_W'(1);
   assign d_one   = x - X1;
   assign d_three = x - X3;
   assign unused_bits = ^{d_one, d_three, sum};

   // stage 1: segment selection
   always_comb begin
      if (x >= X7) begin
         a0 = curve[PT_SEVEN]; b0 = curve[PT_SEVEN]; w0 = '0;
      end else if (x >= X3) begin
         a0 = curve[PT_THREE]; b0 = curve[PT_SEVEN]; w0 = d_three[W_B-1:0];
      end else if (x >= X1) begin
         a0 = curve[PT_ONE];   b0 = curve[PT_THREE]; w0 = {d_one[W_B-2:0], 1'b0};
      end else begin
         a0 = curve[k];        b0 = curve[kn];
         w0 = W_B'(x[BL-1:0]) << (W_B - BL);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         a1 <= '0; b1 <= '0; w1 <= '0; x1 <= '0; byp1 <= 1'b1;
      end else if (accept) begin
         a1 <= a0; b1 <= b0; w1 <= w0; x1 <= x; byp1 <= !en;
      end
   end

   // stage 2: blend
   assign diff = $signed({2'b00, b1}) - $signed({2'b00, a1});
   assign prod = PW'(diff) * PW'($signed({1'b0, w1}));
   assign sum  = PW'($signed({1'b0, a1})) + (prod >>> W_B);

   always_ff @(posedge clk) begin
      if (rst) y <= '0;
      else     y <= byp1 ? x1 : PIX_W'(sum[ENTRY_W-1:0]);
   end
endmodule

// File: rtl/degamma_lut.sv
module degamma_lut
   import dgl_pkg::*;
#(
   parameter int NCOMP    = 3,
   parameter int PIX_FRAC = 16,
   parameter int PIX_INT  = 3,
   parameter int ENTRY_W  = 17,
   parameter int AINC_BIT = 8
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic [1:0]                          reg_addr,
   input  logic [31:0]                         reg_wdata,
   input  logic                                reg_wr,
   input  logic                                reg_rd,
   output logic [31:0]                         reg_rdata,
   input  logic                                pix_valid_i,
   input  logic [NCOMP*(PIX_INT+PIX_FRAC)-1:0] pix_i,
   output logic                                pix_valid_o,
   output logic [NCOMP*(PIX_INT+PIX_FRAC)-1:0] pix_o
);
   localparam int PIX_W = PIX_INT + PIX_FRAC;

   generate
      if (ENTRY_W < PIX_FRAC + 1) begin : g_bad_entry
         $error("ENTRY_W must hold the value 1.0");
      end
      if (ENTRY_W > PIX_W || ENTRY_W > 32) begin : g_bad_entry_hi
         $error("ENTRY_W too wide for pixel or register");
      end
      if (PIX_INT < 3) begin : g_bad_int
         $error("PIX_INT must reach 7.0");
      end
      if (PIX_FRAC <= SEG_BITS) begin : g_bad_frac
         $error("PIX_FRAC too small for segment select");
      end
      if (AINC_BIT < IDX_W || AINC_BIT > 29) begin : g_bad_ainc
         $error("AINC_BIT overlaps pointer field");
      end
   endgenerate

   logic [NENT-1:0][ENTRY_W-1:0] curve;
   logic [IDX_W-1:0]             cur_idx;
   logic                         auto_inc;
   logic                         pre_en;
   logic                         v1;

   dgl_regs #(.ENTRY_W(ENTRY_W), .PIX_FRAC(PIX_FRAC), .AINC_BIT(AINC_BIT)) u_regs (
      .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata), .wr(reg_wr), .rd(reg_rd),
      .rdata(reg_rdata), .curve(curve), .ptr(cur_idx), .ainc(auto_inc), .deg_en(pre_en)
   );

   generate
      for (genvar c = 0; c < NCOMP; c++) begin : g_comp
         dgl_chan #(.PIX_FRAC(PIX_FRAC), .PIX_INT(PIX_INT), .ENTRY_W(ENTRY_W)) u_chan (
            .clk(clk), .rst(rst), .accept(pix_valid_i), .en(pre_en),
            .x(pix_i[c*PIX_W +: PIX_W]), .curve(curve), .y(pix_o[c*PIX_W +: PIX_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         v1 <= 1'b0; pix_valid_o <= 1'b0;
      end else begin
         v1 <= pix_valid_i; pix_valid_o <= v1;
      end
   end
endmodule

// File: rtl/degamma_lut_chk.sv
module degamma_lut_chk #(
   parameter int BUS_W    = 57,
   parameter int IDX_W    = 6,
   parameter int AINC_BIT = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             reg_wr,
   input logic [1:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic             pix_valid_i,
   input logic [BUS_W-1:0] pix_i,
   input logic             pix_valid_o,
   input logic [BUS_W-1:0] pix_o,
   input logic [IDX_W-1:0] cur_idx,
   input logic             auto_inc,
   input logic             pre_en
);
   localparam logic [IDX_W-1:0] LAST_PT = IDX_W'(34);
   logic [1:0] cyc;

   always_ff @(posedge clk) begin
      if (rst) cyc <= 2'd0;
      else if (cyc != 2'd2) cyc <= cyc + 2'd1;
   end

   AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
      (cyc == 2'd2) |-> (pix_valid_o == $past(pix_valid_i, 2))); // R7
   AST_BYPASS_DATA: assert property (@(posedge clk) disable iff (rst)
      (cyc == 2'd2 && pix_valid_o && !$past(pre_en, 2)) |-> (pix_o == $past(pix_i, 2))); // R7
   AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
      cur_idx <= LAST_PT); // R2
   AST_AINC_HOLD: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == 2'd1 && reg_wdata[AINC_BIT]) |=> ($stable(cur_idx) && auto_inc)); // R3
   AST_AINC_STEP: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == 2'd2 && auto_inc && cur_idx < LAST_PT)
      |=> (cur_idx == $past(cur_idx) + IDX_W'(1))); // R4
   AST_AINC_SAT: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == 2'd2 && auto_inc && cur_idx == LAST_PT) |=> (cur_idx == LAST_PT)); // R4
endmodule

bind degamma_lut degamma_lut_chk #(
   .BUS_W(NCOMP*PIX_W), .IDX_W(dgl_pkg::IDX_W), .AINC_BIT(AINC_BIT)
) chk (
   .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .pix_valid_i(pix_valid_i), .pix_i(pix_i), .pix_valid_o(pix_valid_o), .pix_o(pix_o),
   .cur_idx(cur_idx), .auto_inc(auto_inc), .pre_en(pre_en)
);

// File: tb/degamma_lut_test.sv
`timescale 1ns/1ps
module degamma_lut_test;
   localparam int PW = 19;
   localparam int ONE = 65536;
   localparam int NV = 8;
   localparam int VIN  [NV] = '{0, 12345, 65535, 65536, 131072, 196608, 300000, 524287};
   localparam int VEXP [NV] = '{0, 12345, 65535, 65536, 65536,  65536,  65536,  65536};

   logic clk = 0, rst = 1;
   logic [1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic reg_wr = 0, reg_rd = 0;
   logic [31:0] reg_rdata;
   logic pix_valid_i = 0;
   logic [3*PW-1:0] pix_i = '0;
   logic pix_valid_o;
   logic [3*PW-1:0] pix_o;

   int checks = 0, errors = 0;
   bit done = 0;
   longint mt [35];
   int got [3];
   bit vmid, vout;

   always #4 clk = ~clk;

   degamma_lut uut (
      .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pix_valid_i(pix_valid_i), .pix_i(pix_i),
      .pix_valid_o(pix_valid_o), .pix_o(pix_o)
   );

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1;
      @(negedge clk); reg_rd = 0; d = reg_rdata;
   endtask

   // drive one pixel; optional same-cycle register write
   task automatic pix3(input int x0, input int x1, input int x2,
                       input bit wr_too, input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      pix_i = {PW'(x2), PW'(x1), PW'(x0)}; pix_valid_i = 1;
      if (wr_too) begin reg_addr = a; reg_wdata = d; reg_wr = 1; end
      @(negedge clk); pix_valid_i = 0; reg_wr = 0; vmid = pix_valid_o;
      @(negedge clk); vout = pix_valid_o;
      for (int c = 0; c < 3; c++) got[c] = int'(pix_o[c*PW +: PW]);
   endtask

   function automatic longint model(longint x);
      longint a, b, w;
      if (x >= 7*ONE) return mt[34];
      if (x >= 3*ONE) begin a = mt[33]; b = mt[34]; w = x - 3*ONE; end
      else if (x >= ONE) begin a = mt[32]; b = mt[33]; w = (x - ONE) * 2; end
      else begin a = mt[x >> 11]; b = mt[(x >> 11) + 1]; w = (x & 2047) * 128; end
      return a + (((b - a) * w) >>> 18);
   endfunction

   initial begin
      #1_600_000;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int tin [12];
      repeat (3) @(negedge clk);
      rst = 0;

      // R1: reset state
      reg_read(2'd0, r); check("R1 mode", r, 0);
      reg_read(2'd1, r); check("R1 ptr", r, 0);
      for (int i = 0; i < 35; i++) mt[i] = (i <= 32) ? i * 2048 : ONE;
      reg_write(2'd1, 32'h0);
      reg_write(2'd1, 32'h100);
      for (int i = 0; i < 35; i++) begin
         reg_read(2'd2, r); check("R1 R5 default point", r, mt[i]);
      end
      reg_read(2'd1, r); check("R5 read advance saturates", r, 32'h100 | 34);

      // R7: bypass
      pix3(12345, 400000, 70000, 0, 0, 0);
      check("R7 valid mid", vmid, 0); check("R7 valid out", vout, 1);
      check("R7 bypass c0", got[0], 12345);
      check("R7 bypass c1", got[1], 400000);
      check("R7 bypass c2", got[2], 70000);

      // R6
      reg_write(2'd0, 32'hC0F0_0F03);
      reg_read(2'd0, r); check("R6 mode readback", r, 32'hC000_0003);

      // R8 R9 R10 with identity curve
      for (int i = 0; i < NV; i++) begin
         pix3(VIN[i], VIN[(i+3)%NV], VIN[(i+5)%NV], 0, 0, 0);
         check("R8 R9 R10 vec c0", got[0], VEXP[i]);
         check("R8 R9 R10 vec c1", got[1], VEXP[(i+3)%NV]);
         check("R8 R9 R10 vec c2", got[2], VEXP[(i+5)%NV]);
      end

      // R2 R4: reload the curve
      for (int i = 0; i < 33; i++) mt[i] = i * i * 60 + ((i == 20) ? 20000 : 0);
      mt[33] = 100000; mt[34] = 120000;
      reg_write(2'd1, 32'd0);
      reg_write(2'd1, 32'h100);
      for (int i = 0; i < 35; i++) reg_write(2'd2, 32'(mt[i]));
      reg_read(2'd1, r); check("R4 ptr saturate", r, 32'h100 | 34);
      reg_write(2'd2, 32'hFFFE_0000 | 130000); mt[34] = 130000;
      reg_read(2'd1, r); check("R4 ptr stays 34", r, 32'h100 | 34);
      reg_write(2'd1, 32'd5);
      reg_read(2'd2, r); check("R5 read point 5", r, mt[5]);
      reg_read(2'd1, r); check("R5 no advance", r, 5);
      reg_write(2'd1, 32'd40);
      reg_read(2'd1, r); check("R2 out of range ignored", r, 5);
      reg_write(2'd1, 32'd20);
      reg_write(2'd1, 32'h107);
      reg_read(2'd1, r); check("R3 flag keeps ptr", r, 32'h100 | 20);
      reg_write(2'd1, 32'd34);
      reg_read(2'd2, r); check("R4 last point", r, 130000);

      // R8 R9 R10 with shaped curve
      tin = '{20*2048 + 1000, 19*2048 + 2047, 0, 65535, 65536, 65536 + 33333,
              3*ONE - 1, 3*ONE, 5*ONE + 7, 7*ONE - 1, 7*ONE, 524287};
      for (int i = 0; i < 12; i += 3) begin
         pix3(tin[i], tin[i+1], tin[i+2], 0, 0, 0);
         check("R8 R9 R10 shaped c0", got[0], model(tin[i]));
         check("R8 R9 R10 shaped c1", got[1], model(tin[i+1]));
         check("R8 R9 R10 shaped c2", got[2], model(tin[i+2]));
      end

      // R11: write to point 10 in same cycle as pixel on point 10
      reg_write(2'd1, 32'd10);
      pix3(10*2048, 10*2048, 0, 1, 2'd2, 32'd77777);
      check("R11 old point used", got[0], mt[10]);
      mt[10] = 77777;
      pix3(10*2048, 0, 0, 0, 0, 0);
      check("R11 new point used", got[0], 77777);

      // R12: disable in same cycle as pixel
      pix3(3*ONE, 0, 0, 1, 2'd0, 32'h0);
      check("R12 old enable used", got[0], mt[33]);
      pix3(3*ONE, 0, 0, 0, 0, 0);
      check("R12 bypass after", got[0], 3*ONE);

      // R1 again: reset restores defaults
      @(negedge clk); rst = 1; repeat (2) @(negedge clk); rst = 0;
      reg_read(2'd2, r); check("R1 point 0 after reset", r, 0);
      reg_write(2'd1, 32'd10);
      reg_read(2'd2, r); check("R1 point 10 after reset", r, 20480);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule